// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block gathers level-sensitive interrupt requests from a set of numbered sources and hands them out to two service targets (contexts). Software assigns each source a small priority, chooses per context which sources it wants to see, and sets a per-context floor (threshold) that a source's priority must beat. Each context has an interrupt line that is high whenever some source qualifies for it.

A service target reads its claim register to learn which source to handle. That read also retires the source, so no other context can take it. The source's gateway then ignores its request line until the handler writes the same id back to a claim register, which marks the work as complete. All registers sit on a plain 32-bit read/write bus. Read data is combinational, and a write takes effect at the clock edge.

Source numbers run from 1 to the configured count. Number 0 means "nothing".

Top module: `plic_core`

## Requirements
- R1: The priority of source n is at byte address 4·n. It is 3 bits wide and the upper bits read as 0. Address 0, the reserved source, reads 0 and ignores writes.
- R2: The enable word of context c is at byte address 0x2000 + 0x80·c. Bit n enables source n. Bit 0 always reads 0.
- R3: The threshold of context c is at byte address 0x200000 + 0x1000·c. It is 3 bits wide and the upper bits read as 0.
- R4: A source is eligible for a context when it is pending, enabled for that context, and its priority is strictly greater than that context's threshold. `ctx_irq[c]` is high in the same cycle whenever any source is eligible for context c. A priority of 0 therefore never interrupts.
- R5: A read of the claim register of context c (byte address 0x200004 + 0x1000·c) returns the eligible source with the highest priority. Ties go to the lowest id. The read returns 0 when no source is eligible.
- R6: A claim read clears the returned source's pending bit at that clock edge. The source cannot become pending again until it is completed, whatever its input does.
- R7: Writing id n to any context's claim register completes source n only if n is currently claimed. After completion, a still-high input makes the source pending again. A write of an id that is not claimed has no effect.
- R8: A read of an unmapped address returns 0. A write to an unmapped address changes nothing. Unmapped addresses include source ids above the count, context numbers of 2 and above, and other words in the enable and context regions.
- R9: After reset, all priorities, enables, thresholds and pending bits are 0, and every gateway is armed.
- R10: An armed gateway latches a request that is high for a single cycle. The source stays pending until it is claimed, even after its input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NUM_SRC (bits NUM_SRC..1) | Level request of source n on bit n |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of a claim register retires the source |
| bus_addr | input | 26 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| ctx_irq | output | NUM_CTX | Interrupt line per context |

## Verification
On every cycle, the assertions check the gateway rules: a claim empties the pending bit, an in-service source cannot become pending, and a completion re-arms the gateway. They also check that the reported winner really is eligible, that at most one source is retired per cycle, and that an idle claim read or an unmapped read returns 0. Two behaviours can only be shown by the bench's scenarios, driven against its own model: the full winner choice (priority order, lowest-id tie-break, threshold cut-off), and the fact that unclaimed completions and unmapped writes leave state unchanged.

// File: rtl/plic_pkg.sv
package plic_pkg;

  localparam logic [25:0] EN_BASE    = 26'h0002000;
  localparam logic [25:0] CTX_BASE   = 26'h0200000;

  typedef enum logic [2:0] {
    K_NONE, K_PRIO, K_EN, K_THR, K_CLAIM
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [15:0] idx;
    logic [15:0] ctx;
  } dec_t;

  // Map a byte address to register kind, source index and context number.
  function automatic dec_t decode(input logic [25:0] a);
    dec_t        d;
    logic [25:0] off;
    d.kind = K_NONE;
    d.idx  = 16'd0;
    d.ctx  = 16'd0;
    if (a < EN_BASE) begin
      d.kind = K_PRIO;
      d.idx  = 16'(a[12:2]);
    end else if (a < CTX_BASE) begin
      off   = a - EN_BASE;
      d.ctx = 16'(off[25:7]);
      if (off[6:2] == 5'd0) d.kind = K_EN;
    end else begin
      off   = a - CTX_BASE;
      d.ctx = 16'(off[25:12]);
      if (off[11:2] == 10'd0)      d.kind = K_THR;
      else if (off[11:2] == 10'd1) d.kind = K_CLAIM;
    end
    return d;
  endfunction

endpackage

// File: rtl/plic_gateway.sv
module plic_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic in_service_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_o    <= 1'b0;
      in_service_o <= 1'b0;
    end else if (claim_i) begin
      pending_o    <= 1'b0;
      in_service_o <= 1'b1;
    end else begin
      if (complete_i) in_service_o <= 1'b0;
      if (!in_service_o && req_in) pending_o <= 1'b1;
    end
  end

  // R6: a claim empties the pending bit
  p_claim_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |=> !pending_o);

  // R6: no new request while the source is in service
  p_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service_o && !claim_i) |=> !pending_o);

  // R7: completion re-arms the gateway
  p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_i && !claim_i) |=> !in_service_o);

endmodule

// File: rtl/plic_select.sv
module plic_select #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC:0]              pending,
  input  logic [NUM_SRC:0]              enable,
  input  logic [NUM_SRC:0][PRIO_W-1:0]  prio,
  input  logic [PRIO_W-1:0]             threshold,
  output logic [ID_W-1:0]               best_id,
  output logic                          any_o
);

  logic [PRIO_W-1:0] best_p;

  // Strict compare keeps the lowest id on ties; id 0 never wins since its
  // priority is held at 0 and cannot exceed any threshold.
  always_comb begin
    best_id = '0;
    best_p  = '0;
    for (int i = 0; i <= NUM_SRC; i++) begin
      if (pending[i] && enable[i] && (prio[i] > threshold) && (prio[i] > best_p)) begin
        best_id = ID_W'(i);
        best_p  = prio[i];
      end
    end
  end

  assign any_o = (best_id != '0);

  // R4: the reported winner is pending, enabled and above threshold
  p_winner_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (pending[best_id] && enable[best_id] && (prio[best_id] > threshold)));

endmodule

// File: rtl/plic_core.sv
module plic_core
  import plic_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC:1]    src_irq,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [25:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_CTX-1:0]  ctx_irq
);

  localparam int ID_W  = $clog2(NUM_SRC + 1);
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

  logic [NUM_SRC:0][PRIO_W-1:0]  prio_q;
  logic [NUM_CTX-1:0][NUM_SRC:0] en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q;
  logic [NUM_SRC:0]              pend, svc, claim_v, done_v;
  logic [NUM_CTX-1:0][ID_W-1:0]  best_id;

  dec_t             dec;
  logic             ctx_ok, idx_ok, claim_rd, done_wr;
  logic [CTX_W-1:0] cx;

  always_comb begin
    dec      = decode(bus_addr);
    ctx_ok   = (dec.ctx < 16'(NUM_CTX));
    idx_ok   = (dec.idx >= 16'd1) && (dec.idx <= 16'(NUM_SRC));
    cx       = dec.ctx[CTX_W-1:0];
    claim_rd = bus_rd && (dec.kind == K_CLAIM) && ctx_ok;
    done_wr  = bus_wr && (dec.kind == K_CLAIM) && ctx_ok;
  end

  // Retire / complete strobes per source
  always_comb begin
    claim_v = '0;
    done_v  = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      claim_v[i] = claim_rd && (best_id[cx] == ID_W'(i));
      done_v[i]  = done_wr && (bus_wdata == 32'(i)) && svc[i];
    end
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (bus_wr) begin
      case (dec.kind)
        K_PRIO: if (idx_ok) prio_q[dec.idx[ID_W-1:0]] <= bus_wdata[PRIO_W-1:0];
        K_EN:   if (ctx_ok) en_q[cx] <= {bus_wdata[NUM_SRC:1], 1'b0};
        K_THR:  if (ctx_ok) thr_q[cx] <= bus_wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  assign pend[0] = 1'b0;
  assign svc[0]  = 1'b0;

  for (genvar g = 1; g <= NUM_SRC; g++) begin : g_gw
    plic_gateway u_gw (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_in       (src_irq[g]),
      .claim_i      (claim_v[g]),
      .complete_i   (done_v[g]),
      .pending_o    (pend[g]),
      .in_service_o (svc[g])
    );
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    plic_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .pending   (pend),
      .enable    (en_q[c]),
      .prio      (prio_q),
      .threshold (thr_q[c]),
      .best_id   (best_id[c]),
      .any_o     (ctx_irq[c])
    );
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    case (dec.kind)
      K_PRIO:  if (idx_ok) bus_rdata = 32'(prio_q[dec.idx[ID_W-1:0]]);
      K_EN:    if (ctx_ok) bus_rdata = 32'(en_q[cx]);
      K_THR:   if (ctx_ok) bus_rdata = 32'(thr_q[cx]);
      K_CLAIM: if (ctx_ok) bus_rdata = 32'(best_id[cx]);
      default: ;
    endcase
  end

  // R5: an idle context's claim returns 0
  p_claim_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_rd && !ctx_irq[cx]) |-> (bus_rdata == 32'd0));

  // R6: at most one source is retired per cycle
  p_claim_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_v));

  // R8: unmapped reads return 0
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (dec.kind == K_NONE)) |-> (bus_rdata == 32'd0));

endmodule

// File: tb/sim_plic_core.sv
module sim_plic_core;
  localparam int NS = 31;
  localparam int NC = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [NS:1]   src;
  logic          bus_wr, bus_rd;
  logic [25:0]   bus_addr;
  logic [31:0]   bus_wdata;
  wire  [31:0]   bus_rdata;
  wire  [NC-1:0] ctx_irq;

  plic_core #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .src_irq(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctx_irq(ctx_irq)
  );

  int n_chk = 0, n_fail = 0;
  int m_prio[32];
  logic [31:0] m_en[NC];
  int m_thr[NC];
  bit m_pend[32];
  bit m_svc[32];
  logic [31:0] last_rd;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_best(int c);
    int b = 0, bp = 0;
    for (int i = 1; i <= NS; i++)
      if (m_pend[i] && m_en[c][i] && m_prio[i] > m_thr[c] && m_prio[i] > bp) begin
        b = i; bp = m_prio[i];
      end
    return b;
  endfunction

  // Behavioural register map: returns value, sets tag
  function automatic logic [31:0] m_read(int a, output string tag);
    int c, w;
    tag = "R8";
    if (a < 'h2000) begin
      if (a / 4 >= 1 && a / 4 <= NS) begin tag = "R1"; return m_prio[a/4]; end
      return 0;
    end else if (a < 'h200000) begin
      c = (a - 'h2000) / 'h80; w = ((a - 'h2000) % 'h80) / 4;
      if (c < NC && w == 0) begin tag = "R2"; return m_en[c]; end
      return 0;
    end else begin
      c = (a - 'h200000) / 'h1000; w = ((a - 'h200000) % 'h1000) / 4;
      if (c < NC && w == 0) begin tag = "R3"; return m_thr[c]; end
      if (c < NC && w == 1) begin tag = "R5"; return m_best(c); end
      return 0;
    end
  endfunction

  function automatic int claim_ctx(int a);
    if (a >= 'h200000 && ((a - 'h200000) % 'h1000) / 4 == 1 && (a - 'h200000) / 'h1000 < NC)
      return (a - 'h200000) / 'h1000;
    return -1;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 32; i++) begin m_prio[i] = 0; m_pend[i] = 0; m_svc[i] = 0; end
    for (int c = 0; c < NC; c++) begin m_en[c] = 0; m_thr[c] = 0; end
  endtask

  task automatic m_edge();
    int a = int'(bus_addr);
    int cl = 0, cm = 0, c, w;
    bit svc_old[32];
    c = claim_ctx(a);
    if (bus_rd && c >= 0) cl = m_best(c);
    if (bus_wr && c >= 0 && bus_wdata >= 1 && bus_wdata <= NS && m_svc[bus_wdata]) cm = int'(bus_wdata);
    if (bus_wr) begin
      if (a < 'h2000) begin
        if (a / 4 >= 1 && a / 4 <= NS) m_prio[a/4] = bus_wdata & 7;
      end else if (a < 'h200000) begin
        c = (a - 'h2000) / 'h80; w = ((a - 'h2000) % 'h80) / 4;
        if (c < NC && w == 0) m_en[c] = bus_wdata & 32'hFFFF_FFFE;
      end else begin
        c = (a - 'h200000) / 'h1000; w = ((a - 'h200000) % 'h1000) / 4;
        if (c < NC && w == 0) m_thr[c] = bus_wdata & 7;
      end
    end
    for (int i = 0; i < 32; i++) svc_old[i] = m_svc[i];
    for (int i = 1; i <= NS; i++) begin
      if (i == cl) begin m_pend[i] = 0; m_svc[i] = 1; end
      else if (i == cm) m_svc[i] = 0;
      else if (!svc_old[i] && src[i]) m_pend[i] = 1;
    end
  endtask

  // One cycle: compare at mid-low phase, update model at the edge
  task automatic step();
    string tag;
    logic [31:0] e;
    #1;
    for (int c = 0; c < NC; c++) chk("R4", 32'(ctx_irq[c]), 32'(m_best(c) != 0));
    if (bus_rd) begin
      e = m_read(int'(bus_addr), tag);
      chk(tag, bus_rdata, e);
      last_rd = bus_rdata;
    end
    @(posedge clk);
    m_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    step();
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_wr = 1; bus_rd = 0; bus_addr = 26'(a); bus_wdata = d;
    step();
    bus_wr = 0;
  endtask

  task automatic rd(int a);
    bus_wr = 0; bus_rd = 1; bus_addr = 26'(a); bus_wdata = '0;
    step();
    bus_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; src = '0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();

    // R9: reset state
    rd(4 * 5);        chk("R9", last_rd, 0);
    rd('h201000);     chk("R9", last_rd, 0);
    rd('h2080);       chk("R9", last_rd, 0);
    rd('h200004);     chk("R9", last_rd, 0);
    chk("R9", 32'(ctx_irq), 0);

    // R1: priority width and reserved id 0
    wr(4 * 5, 32'hFF); rd(4 * 5); chk("R1", last_rd, 7);
    wr(0, 5);          rd(0);     chk("R1", last_rd, 0);
    wr(4 * 5, 0);

    // R2: enable words, bit 0 reserved
    wr('h2000, 32'hFFFF_FFFF); rd('h2000); chk("R2", last_rd, 32'hFFFF_FFFE);
    wr('h2080, 32'h81);        rd('h2080); chk("R2", last_rd, 32'h80);

    // R3: threshold width
    wr('h201000, 9); rd('h201000); chk("R3", last_rd, 1);
    wr('h201000, 0);

    // R8: unmapped accesses
    wr('h2100, 32'hFF);  rd('h2100);   chk("R8", last_rd, 0);
    wr('h2004, 32'h0);   rd('h2000);   chk("R8", last_rd, 32'hFFFF_FFFE);
    wr('h202000, 3);     rd('h202000); chk("R8", last_rd, 0);
    rd('h200008);        chk("R8", last_rd, 0);
    wr(4 * 40, 7);       rd(4 * 40);   chk("R8", last_rd, 0);

    // R4/R5: arbitration with ties and a zero-priority source
    wr(4 * 3, 5); wr(4 * 7, 5); wr(4 * 2, 2); wr(4 * 9, 0);
    src[2] = 1; src[3] = 1; src[7] = 1; src[9] = 1;
    idle(); idle();
    chk("R4", 32'(ctx_irq), 2'b11);
    rd('h200004); chk("R5", last_rd, 3);
    rd('h200004); chk("R5", last_rd, 7);
    chk("R6", 32'(ctx_irq[1]), 0);
    rd('h201004); chk("R5", last_rd, 0);
    rd('h200004); chk("R5", last_rd, 2);
    rd('h200004); chk("R4", last_rd, 0);

    // R4: threshold cut-off is strict
    wr('h200004, 2); idle();
    wr('h200000, 2); rd('h200004); chk("R4", last_rd, 0);
    wr('h200000, 1); rd('h200004); chk("R4", last_rd, 2);

    // R6/R7: blocked while in service; unclaimed completion ignored
    src[3] = 0; idle(); src[3] = 1; idle();
    rd('h200004); chk("R6", last_rd, 0);
    wr('h200004, 5);  idle();
    rd('h200004); chk("R7", last_rd, 0);
    wr('h201004, 3);  idle();
    rd('h200004); chk("R7", last_rd, 3);

    // R10: a one-cycle pulse is held
    wr(4 * 11, 4);
    src[11] = 1; idle(); src[11] = 0;
    idle(); idle();
    rd('h200004); chk("R10", last_rd, 11);
    rd('h200004); chk("R10", last_rd, 0);

    idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule